// File: doc/BRIEF.md
# Infrared remote control receiver

This block turns the demodulated output of an infrared receiver module into data words. It watches one active-low input pin, clocked by a slow sampling clock. It measures pulse widths in sampling clocks and recognises a start mark made of one long low phase and one long high phase. It then turns each later falling-edge-to-falling-edge period into a 0 or a 1 and shifts the bits into a working register of up to 72 bits. When the frame ends, the working register and its bit count are copied to the outputs. A status flag is set and an interrupt pulse is raised.

A frame ends in one of three ways. The input can stay low for too long. A bit period can grow past a programmed maximum. When any end-count value is programmed, that second kind of ending is kept only if the number of received bits matches one of the programmed counts. A leaderless mode skips the start mark, so the first falling edge begins the first bit. Results are not held back for software: each accepted frame overwrites the previous one. Configuration is static and is set while the block is disabled.

Top module: `irRemoteRx`

## Requirements
- R1: While `enable` is low the block stays idle. No frame starts, `irq` stays low, and `rxBuf`, `rxBitCnt` and the status flags keep their values whatever the pin does.
- R2: All widths are counted in sampling clocks on the pin after a two-stage synchronizer. A start mark is accepted only when the low width lies in [`cfgLdrLowMin`, `cfgLdrLowMax`] and the next high width lies in [`cfgLdrHighMin`, `cfgLdrHighMax`], both bounds inclusive. On acceptance, at the falling edge that ends the high phase, `stLeader` is set. A mark outside these limits leaves every output unchanged.
- R3: When `cfgLdrIrqEn` is 1, an accepted start mark also raises an `irq` pulse. When it is 0, no pulse is raised for the start mark.
- R4: A data bit is 1 when its falling-to-falling period is greater than `cfgBitThresh`, and 0 otherwise. Bits shift in at bit 0, so the last bit received sits in `rxBuf[0]` and the first of N bits sits in `rxBuf[N-1]`. Bits above N read 0.
- R5: When `cfgEdgeIrqEn` is 1, every falling edge that ends a data bit sets `stEdge` and raises an `irq` pulse. When it is 0, neither happens.
- R6: While a frame is in progress, a low width greater than `cfgLowMax` completes the frame. `rxBuf` and `rxBitCnt` are loaded, `stDone` is set, `irq` pulses, and the block waits for the next start mark.
- R7: With all end counts at 0, a period since the last falling edge greater than `cfgCycleMax` completes the frame in the same way.
- R8: `cfgEndCnts` holds three 7-bit counts, with count k in bits [7k+6:7k]; a count of 0 means unused. With any count nonzero, a cycle timeout completes the frame only if the bit count equals a nonzero count. Otherwise the frame is dropped with no `irq`, and `rxBuf` and `rxBitCnt` stay as they were.
- R9: At most 72 bits are stored. Bits after the 72nd are ignored, and `rxBitCnt` stops at 72.
- R10: With `cfgNoLeader` at 1, the first falling edge starts the first data bit with no start mark. `stLeader` reads 0 for that frame.
- R11: The start of each new frame clears `stEdge` and `stDone` (and `stLeader` in leaderless mode). A later completed frame overwrites `rxBuf` and `rxBitCnt` without any read.
- R12: `irq` is high for exactly one clock per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Arms reception |
| rxPin | input | 1 | Raw infrared input, idle high |
| cfgNoLeader | input | 1 | Leaderless mode |
| cfgLdrIrqEn | input | 1 | Interrupt on an accepted start mark |
| cfgEdgeIrqEn | input | 1 | Interrupt and flag on each data falling edge |
| cfgLdrLowMin | input | CNT_W | Minimum start-mark low width |
| cfgLdrLowMax | input | CNT_W | Maximum start-mark low width |
| cfgLdrHighMin | input | CNT_W | Minimum start-mark high width |
| cfgLdrHighMax | input | CNT_W | Maximum start-mark high width |
| cfgBitThresh | input | CNT_W | Period above which a bit is 1 |
| cfgCycleMax | input | CNT_W | Bit period timeout |
| cfgLowMax | input | CNT_W | Low width timeout |
| cfgEndCnts | input | N_END*BCNT_W | Packed end bit counts, 0 = unused |
| rxBuf | output | BUF_BITS | Bits of the last completed frame |
| rxBitCnt | output | BCNT_W | Bit count of the last completed frame |
| stLeader | output | 1 | Start mark accepted |
| stEdge | output | 1 | Data falling edge seen |
| stDone | output | 1 | Frame completed |
| irq | output | 1 | Interrupt pulse |

## Verification
A width counter that is cleared on the wrong edge shows at once as a wrong bit value. It appears in `rxBuf` on the clock the frame completes, and a start mark near its window limits can be accepted or rejected in error. A wrong state for the controller shows as an `irq` pulse or a flag change on the very clock of the falling edge involved. A frame that should have been kept may be dropped, and then `stDone` stays low after the timeout window. The reference model is compared with every output on every clock, so a fault shows no later than the next event it affects.

// File: rtl/irRxPkg.sv
`timescale 1ns/1ps
package irRxPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LDR_LOW,
    ST_LDR_HIGH,
    ST_DATA
  } rxState_e;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic cntClr;
    logic frameStart;
    logic setLeader;
    logic shiftBit;
    logic setEdge;
    logic commit;
  } rxStrobe_t;

endpackage

// File: rtl/irRxSync.sv
`timescale 1ns/1ps
module irRxSync #(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic lvl,
  output logic fall,
  output logic rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1 <= IDLE_LVL;
      s2 <= IDLE_LVL;
      s3 <= IDLE_LVL;
    end else begin
      s1 <= pinIn;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign lvl  = s2;
  assign fall = s3 & ~s2;
  assign rise = ~s3 & s2;
endmodule

// File: rtl/irRxCtrl.sv
`timescale 1ns/1ps
module irRxCtrl
  import irRxPkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             cfgNoLeader,
  input  logic             cfgEdgeIrqEn,
  input  logic [CNT_W-1:0] cfgLdrLowMin,
  input  logic [CNT_W-1:0] cfgLdrLowMax,
  input  logic [CNT_W-1:0] cfgLdrHighMin,
  input  logic [CNT_W-1:0] cfgLdrHighMax,
  input  logic [CNT_W-1:0] cfgCycleMax,
  input  logic [CNT_W-1:0] cfgLowMax,
  input  logic             rxFall,
  input  logic             rxRise,
  input  logic [CNT_W-1:0] widthCnt,
  input  logic [CNT_W-1:0] lowCnt,
  input  logic             endArmed,
  input  logic             endMatch,
  output rxStrobe_t        strobe
);
  rxState_e state, stateNxt;

  logic lowInWin, highInWin, lowOver, cycOver;
  assign lowInWin  = (widthCnt >= cfgLdrLowMin) && (widthCnt <= cfgLdrLowMax);
  assign highInWin = (widthCnt >= cfgLdrHighMin) && (widthCnt <= cfgLdrHighMax);
  assign lowOver   = lowCnt > cfgLowMax;
  assign cycOver   = widthCnt > cfgCycleMax;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    if (!enable) begin
      stateNxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (rxFall) begin
            strobe.cntClr = 1'b1;
            if (cfgNoLeader) begin
              strobe.frameStart = 1'b1;
              stateNxt = ST_DATA;
            end else begin
              stateNxt = ST_LDR_LOW;
            end
          end
        end
        ST_LDR_LOW: begin
          if (rxRise) begin
            strobe.cntClr = 1'b1;
            stateNxt = lowInWin ? ST_LDR_HIGH : ST_IDLE;
          end else if (widthCnt > cfgLdrLowMax) begin
            stateNxt = ST_IDLE;
          end
        end
        ST_LDR_HIGH: begin
          if (rxFall) begin
            strobe.cntClr = 1'b1;
            if (highInWin) begin
              strobe.frameStart = 1'b1;
              strobe.setLeader  = 1'b1;
              stateNxt = ST_DATA;
            end else begin
              stateNxt = ST_IDLE;
            end
          end else if (widthCnt > cfgLdrHighMax) begin
            stateNxt = ST_IDLE;
          end
        end
        ST_DATA: begin
          if (lowOver) begin
            strobe.commit = 1'b1;
            stateNxt = ST_IDLE;
          end else if (cycOver) begin
            strobe.commit = !endArmed || endMatch;
            stateNxt = ST_IDLE;
          end else if (rxFall) begin
            strobe.cntClr   = 1'b1;
            strobe.shiftBit = 1'b1;
            strobe.setEdge  = cfgEdgeIrqEn;
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end
endmodule

// File: rtl/irRxData.sv
`timescale 1ns/1ps
module irRxData
  import irRxPkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int BUF_BITS = 72,
  parameter int N_END    = 3,
  parameter int BCNT_W   = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  rxStrobe_t               strobe,
  input  logic                    rxLvl,
  input  logic                    cfgLdrIrqEn,
  input  logic [CNT_W-1:0]        cfgBitThresh,
  input  logic [N_END*BCNT_W-1:0] cfgEndCnts,
  output logic [CNT_W-1:0]        widthCnt,
  output logic [CNT_W-1:0]        lowCnt,
  output logic                    endArmed,
  output logic                    endMatch,
  output logic [BUF_BITS-1:0]     rxBuf,
  output logic [BCNT_W-1:0]       rxBitCnt,
  output logic                    stLeader,
  output logic                    stEdge,
  output logic                    stDone,
  output logic                    irq
);
  localparam logic [BCNT_W-1:0] BIT_CAP = BCNT_W'(BUF_BITS);

  logic [BUF_BITS-1:0] work;
  logic [BCNT_W-1:0]   bitCnt;
  logic                newBit, bufRoom;

  assign newBit  = widthCnt > cfgBitThresh;
  assign bufRoom = bitCnt < BIT_CAP;

  // end-count comparators, one per programmed slot
  logic [N_END-1:0] armVec, hitVec;
  for (genvar g = 0; g < N_END; g++) begin : gEnd
    logic [BCNT_W-1:0] endVal;
    assign endVal    = cfgEndCnts[g*BCNT_W +: BCNT_W];
    assign armVec[g] = endVal != '0;
    assign hitVec[g] = armVec[g] && (endVal == bitCnt);
  end
  assign endArmed = |armVec;
  assign endMatch = |hitVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthCnt <= '0;
      lowCnt   <= '0;
    end else begin
      if (strobe.cntClr)       widthCnt <= CNT_W'(1);
      else if (widthCnt != '1) widthCnt <= widthCnt + 1'b1;
      if (rxLvl)               lowCnt <= '0;
      else if (lowCnt != '1)   lowCnt <= lowCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      work   <= '0;
      bitCnt <= '0;
    end else if (strobe.frameStart) begin
      work   <= '0;
      bitCnt <= '0;
    end else if (strobe.shiftBit && bufRoom) begin
      work   <= {work[BUF_BITS-2:0], newBit};
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuf    <= '0;
      rxBitCnt <= '0;
      stLeader <= 1'b0;
      stEdge   <= 1'b0;
      stDone   <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (strobe.commit) begin
        rxBuf    <= work;
        rxBitCnt <= bitCnt;
      end
      if (strobe.frameStart) begin
        stLeader <= 1'b0;
        stEdge   <= 1'b0;
        stDone   <= 1'b0;
      end
      if (strobe.setLeader) stLeader <= 1'b1;
      if (strobe.setEdge)   stEdge   <= 1'b1;
      if (strobe.commit)    stDone   <= 1'b1;
      irq <= strobe.commit | strobe.setEdge | (strobe.setLeader & cfgLdrIrqEn);
    end
  end
endmodule

// File: rtl/irRemoteRx.sv
`timescale 1ns/1ps
module irRemoteRx
  import irRxPkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int BUF_BITS = 72,
  parameter int N_END    = 3,
  parameter int BCNT_W   = $clog2(BUF_BITS + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic                    rxPin,
  input  logic                    cfgNoLeader,
  input  logic                    cfgLdrIrqEn,
  input  logic                    cfgEdgeIrqEn,
  input  logic [CNT_W-1:0]        cfgLdrLowMin,
  input  logic [CNT_W-1:0]        cfgLdrLowMax,
  input  logic [CNT_W-1:0]        cfgLdrHighMin,
  input  logic [CNT_W-1:0]        cfgLdrHighMax,
  input  logic [CNT_W-1:0]        cfgBitThresh,
  input  logic [CNT_W-1:0]        cfgCycleMax,
  input  logic [CNT_W-1:0]        cfgLowMax,
  input  logic [N_END*BCNT_W-1:0] cfgEndCnts,
  output logic [BUF_BITS-1:0]     rxBuf,
  output logic [BCNT_W-1:0]       rxBitCnt,
  output logic                    stLeader,
  output logic                    stEdge,
  output logic                    stDone,
  output logic                    irq
);
  logic             rxLvl, rxFall, rxRise, endArmed, endMatch;
  logic [CNT_W-1:0] widthCnt, lowCnt;
  rxStrobe_t        strobe;

  irRxSync #(.IDLE_LVL(1'b1)) uSync (
    .clk(clk), .rstN(rstN), .pinIn(rxPin),
    .lvl(rxLvl), .fall(rxFall), .rise(rxRise)
  );

  irRxCtrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .cfgNoLeader(cfgNoLeader), .cfgEdgeIrqEn(cfgEdgeIrqEn),
    .cfgLdrLowMin(cfgLdrLowMin), .cfgLdrLowMax(cfgLdrLowMax),
    .cfgLdrHighMin(cfgLdrHighMin), .cfgLdrHighMax(cfgLdrHighMax),
    .cfgCycleMax(cfgCycleMax), .cfgLowMax(cfgLowMax),
    .rxFall(rxFall), .rxRise(rxRise),
    .widthCnt(widthCnt), .lowCnt(lowCnt),
    .endArmed(endArmed), .endMatch(endMatch),
    .strobe(strobe)
  );

  irRxData #(.CNT_W(CNT_W), .BUF_BITS(BUF_BITS), .N_END(N_END), .BCNT_W(BCNT_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxLvl(rxLvl),
    .cfgLdrIrqEn(cfgLdrIrqEn), .cfgBitThresh(cfgBitThresh), .cfgEndCnts(cfgEndCnts),
    .widthCnt(widthCnt), .lowCnt(lowCnt), .endArmed(endArmed), .endMatch(endMatch),
    .rxBuf(rxBuf), .rxBitCnt(rxBitCnt),
    .stLeader(stLeader), .stEdge(stEdge), .stDone(stDone), .irq(irq)
  );
endmodule

// File: rtl/irRemoteRxChk.sv
`timescale 1ns/1ps
module irRemoteRxChk #(
  parameter int BUF_BITS = 72,
  parameter int BCNT_W   = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              cfgEdgeIrqEn,
  input logic              irq,
  input logic              stEdge,
  input logic              stDone,
  input logic [BCNT_W-1:0] rxBitCnt
);
  p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !irq);

  p_edge_flag_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stEdge) |-> $past(cfgEdgeIrqEn));

  p_done_raises_irq_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stDone) |-> irq);

  p_count_cap_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxBitCnt <= BCNT_W'(BUF_BITS));

  p_irq_single_r12: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
endmodule

bind irRemoteRx irRemoteRxChk #(.BUF_BITS(BUF_BITS), .BCNT_W(BCNT_W)) uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .cfgEdgeIrqEn(cfgEdgeIrqEn),
  .irq(irq), .stEdge(stEdge), .stDone(stDone), .rxBitCnt(rxBitCnt)
);

// File: tb/irRemoteRx_test.sv
`timescale 1ns/1ps
module irRemoteRx_test;
  localparam int CNT_W = 10;
  localparam int SAT   = 1023;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN, enable, rxPin, cfgNoLeader, cfgLdrIrqEn, cfgEdgeIrqEn;
  logic [9:0]  cfgLdrLowMin, cfgLdrLowMax, cfgLdrHighMin, cfgLdrHighMax;
  logic [9:0]  cfgBitThresh, cfgCycleMax, cfgLowMax;
  logic [20:0] cfgEndCnts;
  logic [71:0] rxBuf;
  logic [6:0]  rxBitCnt;
  logic        stLeader, stEdge, stDone, irq;

  irRemoteRx uut (
    .clk(clk), .rstN(rstN), .enable(enable), .rxPin(rxPin),
    .cfgNoLeader(cfgNoLeader), .cfgLdrIrqEn(cfgLdrIrqEn), .cfgEdgeIrqEn(cfgEdgeIrqEn),
    .cfgLdrLowMin(cfgLdrLowMin), .cfgLdrLowMax(cfgLdrLowMax),
    .cfgLdrHighMin(cfgLdrHighMin), .cfgLdrHighMax(cfgLdrHighMax),
    .cfgBitThresh(cfgBitThresh), .cfgCycleMax(cfgCycleMax), .cfgLowMax(cfgLowMax),
    .cfgEndCnts(cfgEndCnts),
    .rxBuf(rxBuf), .rxBitCnt(rxBitCnt),
    .stLeader(stLeader), .stEdge(stEdge), .stDone(stDone), .irq(irq)
  );

  int vectors = 0;
  int miscompares = 0;
  int irqSeen = 0;
  int irqDouble = 0;
  bit finished = 0;
  logic prevIrq = 1'b0;

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int   mMode, mCnt, mLow, mBits, mBitOut;
  logic m1, m2, m3;
  logic [71:0] mWork, mBuf;
  logic mLdr, mEdge, mDone, mIrq;
  bit   fl, ri, clr, fs, sl, sh, se, cm, bitv;
  bit   armed, hit;
  int   endv [3];

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mCnt = 0; mLow = 0; mBits = 0; mBitOut = 0;
      m1 = 1; m2 = 1; m3 = 1;
      mWork = '0; mBuf = '0;
      mLdr = 0; mEdge = 0; mDone = 0; mIrq = 0;
    end else begin
      fl = m3 && !m2;
      ri = !m3 && m2;
      {clr, fs, sl, sh, se, cm} = '0;
      for (int k = 0; k < 3; k++) endv[k] = int'(cfgEndCnts[k*7 +: 7]);
      armed = 0; hit = 0;
      for (int k = 0; k < 3; k++) begin
        if (endv[k] != 0) begin
          armed = 1;
          if (endv[k] == mBits) hit = 1;
        end
      end
      if (!enable) mMode = 0;
      else if (mMode == 0) begin
        if (fl) begin
          clr = 1;
          if (cfgNoLeader) begin fs = 1; mMode = 3; end
          else mMode = 1;
        end
      end else if (mMode == 1) begin
        if (ri) begin
          clr = 1;
          mMode = (mCnt >= cfgLdrLowMin && mCnt <= cfgLdrLowMax) ? 2 : 0;
        end else if (mCnt > cfgLdrLowMax) mMode = 0;
      end else if (mMode == 2) begin
        if (fl) begin
          clr = 1;
          if (mCnt >= cfgLdrHighMin && mCnt <= cfgLdrHighMax) begin
            fs = 1; sl = 1; mMode = 3;
          end else mMode = 0;
        end else if (mCnt > cfgLdrHighMax) mMode = 0;
      end else begin
        if (mLow > cfgLowMax) begin cm = 1; mMode = 0; end
        else if (mCnt > cfgCycleMax) begin cm = !armed || hit; mMode = 0; end
        else if (fl) begin clr = 1; sh = 1; se = cfgEdgeIrqEn; end
      end
      bitv = mCnt > cfgBitThresh;
      if (fs) begin mWork = '0; mBits = 0; end
      if (sh && mBits < 72) begin mWork = {mWork[70:0], bitv}; mBits++; end
      if (cm) begin mBuf = mWork; mBitOut = mBits; end
      if (fs) begin mLdr = 0; mEdge = 0; mDone = 0; end
      if (sl) mLdr = 1;
      if (se) mEdge = 1;
      if (cm) mDone = 1;
      mIrq = cm || se || (sl && cfgLdrIrqEn);
      mCnt = clr ? 1 : (mCnt < SAT ? mCnt + 1 : mCnt);
      mLow = m2 ? 0 : (mLow < SAT ? mLow + 1 : mLow);
      m3 = m2; m2 = m1; m1 = rxPin;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      vectors++;
      if (rxBuf !== mBuf) begin miscompares++; $display("FAIL R4 rxBuf: actual %h expected %h", rxBuf, mBuf); end
      if (rxBitCnt !== 7'(mBitOut)) begin miscompares++; $display("FAIL R9 rxBitCnt: actual %0d expected %0d", rxBitCnt, mBitOut); end
      if (stLeader !== mLdr) begin miscompares++; $display("FAIL R2 stLeader: actual %b expected %b", stLeader, mLdr); end
      if (stEdge !== mEdge) begin miscompares++; $display("FAIL R5 stEdge: actual %b expected %b", stEdge, mEdge); end
      if (stDone !== mDone) begin miscompares++; $display("FAIL R6 stDone: actual %b expected %b", stDone, mDone); end
      if (irq !== mIrq) begin miscompares++; $display("FAIL R12 irq: actual %b expected %b", irq, mIrq); end
      if (irq === 1'b1) irqSeen++;
      if (irq === 1'b1 && prevIrq === 1'b1) irqDouble++;
      prevIrq = irq;
    end
  end

  task automatic hold(input logic lvl, input int n);
    rxPin = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(input logic [71:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      hold(1'b0, 4);
      hold(1'b1, v[i] ? 12 : 4);
    end
  endtask

  task automatic frame(input bit useLdr, input int lowW, input int highW,
                       input logic [71:0] v, input int n);
    if (useLdr) begin
      hold(1'b0, lowW);
      hold(1'b1, highW);
    end
    sendBits(v, n);
    hold(1'b0, 4);
    hold(1'b1, 60);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rstN = 0; enable = 0; rxPin = 1;
    cfgNoLeader = 0; cfgLdrIrqEn = 1; cfgEdgeIrqEn = 0;
    cfgLdrLowMin = 28; cfgLdrLowMax = 36; cfgLdrHighMin = 12; cfgLdrHighMax = 20;
    cfgBitThresh = 12; cfgCycleMax = 40; cfgLowMax = 30; cfgEndCnts = '0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R11 reset buffer", rxBuf, 72'h0);
    chk("R11 reset flags", {69'h0, stLeader, stDone, irq}, 72'h0);
    enable = 1;
    hold(1'b1, 10);

    // R7 cycle timeout, R3 leader interrupt, R4 bit order
    irqSeen = 0;
    frame(1, 32, 16, 72'hA5, 8);
    chk("R4 byte", rxBuf, 72'hA5);
    chk("R7 count", 72'(rxBitCnt), 72'd8);
    chk("R2 leader flag", 72'(stLeader), 72'd1);
    chk("R3 irq count", 72'(irqSeen), 72'd2);

    // R5 edge interrupts, R11 overwrite
    cfgLdrIrqEn = 0; cfgEdgeIrqEn = 1; irqSeen = 0;
    frame(1, 32, 16, 72'h3C9, 12);
    chk("R11 overwrite", rxBuf, 72'h3C9);
    chk("R5 irq count", 72'(irqSeen), 72'd13);
    chk("R5 edge flag", 72'(stEdge), 72'd1);

    // R6 low-width timeout
    cfgLdrIrqEn = 1; cfgEdgeIrqEn = 0; irqSeen = 0;
    hold(1'b0, 32); hold(1'b1, 16);
    sendBits(72'h5, 3);
    hold(1'b0, 50); hold(1'b1, 60);
    chk("R6 buffer", rxBuf, 72'h5);
    chk("R6 count", 72'(rxBitCnt), 72'd3);
    chk("R6 done", 72'(stDone), 72'd1);

    // R2 start mark outside its windows
    irqSeen = 0;
    frame(1, 20, 16, 72'hFF, 8);
    frame(1, 32, 30, 72'hFF, 8);
    chk("R2 rejected buffer", rxBuf, 72'h5);
    chk("R2 rejected irq", 72'(irqSeen), 72'd0);
    chk("R2 rejected done", 72'(stDone), 72'd1);

    // R8 end counts 8 and 16
    cfgEndCnts = {7'd0, 7'd16, 7'd8};
    frame(1, 32, 16, 72'h5A, 8);
    chk("R8 matched", rxBuf, 72'h5A);
    irqSeen = 0;
    frame(1, 32, 16, 72'h1F, 5);
    chk("R8 dropped buffer", rxBuf, 72'h5A);
    chk("R8 dropped count", 72'(rxBitCnt), 72'd8);
    chk("R8 dropped done", 72'(stDone), 72'd0);
    chk("R8 dropped irq", 72'(irqSeen), 72'd1);
    cfgEndCnts = '0;

    // R10 leaderless
    cfgNoLeader = 1;
    frame(0, 0, 0, 72'h32, 6);
    chk("R10 buffer", rxBuf, 72'h32);
    chk("R10 count", 72'(rxBitCnt), 72'd6);
    chk("R10 leader flag", 72'(stLeader), 72'd0);
    cfgNoLeader = 0;

    // R9 more than 72 bits
    hold(1'b0, 32); hold(1'b1, 16);
    sendBits(72'hC3_0F1E_2D3C_4B5A_6978, 72);
    sendBits(72'h7, 3);
    hold(1'b0, 4); hold(1'b1, 60);
    chk("R9 buffer", rxBuf, 72'hC3_0F1E_2D3C_4B5A_6978);
    chk("R9 count", 72'(rxBitCnt), 72'd72);

    // R1 disabled
    enable = 0; irqSeen = 0;
    frame(1, 32, 16, 72'h9, 4);
    chk("R1 buffer", rxBuf, 72'hC3_0F1E_2D3C_4B5A_6978);
    chk("R1 irq", 72'(irqSeen), 72'd0);
    chk("R1 done", 72'(stDone), 72'd1);
    enable = 1;
    hold(1'b1, 10);

    chk("R12 single pulse", 72'(irqDouble), 72'd0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule